// File: doc/BRIEF.md
# Shift-Add Modular Reduction Unit

This block reduces a 24-bit unsigned product modulo the prime 3329 and uses no hardware multiplier. The prime has the form 13·2^8 + 1, so 2^8 is congruent to −1/13. Splitting a value into a low byte and an upper part therefore lets the unit fold it into a much narrower value. Each fold multiplies the low byte by 13, built from shifts and adds, and subtracts the upper part. Two folds bring a 24-bit product into a small signed range. A final correction stage then maps that value into the canonical interval [0, 3328].

Each fold multiplies the residue class by 13, so the result is congruent to 169·C rather than to C. The unit that feeds the block must cancel this factor, normally by scaling its stored constants by the inverse of 169 ahead of time. The block is a three-stage pipeline. It accepts one product per clock, and a valid strobe travels alongside the data. It is meant to sit directly behind a 12×12 multiplier in a transform butterfly.

Top module: `modfold_reduce`

## Requirements
- R1: For every accepted input C, the output residue equals (169·C) mod 3329 exactly.
- R2: Whenever the output strobe is high, the residue lies in [0, 3328].
- R3: The result for an input sampled at a rising edge appears on the outputs exactly 3 rising edges later, with the output strobe high in that cycle only.
- R4: Inputs presented on consecutive clocks are all accepted, and each produces its own result in order, with no stall or loss.
- R5: While the input strobe is low, the input data is ignored. Three edges later the output strobe is low, and the residue keeps the last value that was produced.
- R6: While reset is asserted, the output strobe is 0 and the residue is 0.
- R7: Corner inputs reduce correctly: 0 and every multiple of 3329 (up to 5039·3329) give 0, and 2^24−1 gives 87.
- R8: The second fold treats the first fold's result as signed. The upper part is the arithmetic right shift by 8, and the low byte is bits 7..0. As a result, negative intermediate values still reduce to the correct residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Input strobe; the product is accepted when high |
| in_prod | input | 24 | Unsigned product to reduce |
| out_valid | output | 1 | Output strobe, high for one cycle per accepted input |
| out_res | output | 12 | Canonical residue congruent to 169·in_prod mod 3329 |

## Verification
A wrong fold shows on the residue port exactly three cycles after the offending input. Typical causes are a dropped shift term in the multiply-by-13, an unsigned upper part in the second pass, or a missing sign extension. In every such case the scoreboard's expected value differs in that same cycle. Large inputs drive the first fold strongly negative, and inputs that are multiples of the modulus must land on zero; both patterns expose sign and correction faults. A fault in the strobe pipeline shows as a strobe one cycle early or late, or as a residue that drifts during idle cycles. Either one is visible in the first cycle it happens.

// File: rtl/modfold_pkg.sv
package modfold_pkg;

  function automatic int unsigned fold_modulus(input int unsigned k, input int unsigned s);
    return k * (32'd1 << s) + 32'd1;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Signed width that holds k*(2^s-1) minus any upper part of width hi_w
  function automatic int unsigned fold_width(input int unsigned hi_w, input int unsigned kbits,
                                             input int unsigned s);
    return max_u(hi_w, kbits + s) + 2;
  endfunction

endpackage

// File: rtl/modfold_pass.sv
module modfold_pass #(
  parameter int unsigned IN_W  = 25,
  parameter int unsigned OUT_W = 18,
  parameter int unsigned K     = 13,
  parameter int unsigned S     = 8,
  localparam int unsigned KB   = $clog2(K + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_in,
  input  logic signed [IN_W-1:0]  x_in,
  output logic                    valid_q,
  output logic signed [OUT_W-1:0] y_q
);

  logic signed [OUT_W-1:0] lo_ext;
  logic signed [OUT_W-1:0] hi_ext;
  logic signed [OUT_W-1:0] term [KB];
  logic signed [OUT_W-1:0] scaled;
  logic signed [OUT_W-1:0] y_d;

  // low slice is unsigned, upper part keeps the sign (arithmetic shift)
  assign lo_ext = {{(OUT_W-S){1'b0}}, x_in[S-1:0]};
  assign hi_ext = {{(OUT_W-(IN_W-S)){x_in[IN_W-1]}}, x_in[IN_W-1:S]};

  // one shifted copy of the low slice for every set bit of the constant
  for (genvar b = 0; b < KB; b++) begin : g_term
    if (((K >> b) & 1) == 1) begin : g_on
      assign term[b] = lo_ext <<< b;
    end else begin : g_off
      assign term[b] = '0;
    end
  end

  always_comb begin
    scaled = '0;
    for (int b = 0; b < KB; b++) begin
      scaled = scaled + term[b];
    end
    y_d = scaled - hi_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      y_q     <= '0;
    end else begin
      valid_q <= en_in;
      if (en_in) begin
        y_q <= y_d;
      end
    end
  end

endmodule

// File: rtl/modfold_canon.sv
module modfold_canon #(
  parameter int unsigned IN_W  = 14,
  parameter int unsigned Q     = 3329,
  parameter int unsigned OUT_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_in,
  input  logic signed [IN_W-1:0] x_in,
  output logic                   valid_q,
  output logic [OUT_W-1:0]       r_q
);

  localparam logic signed [IN_W-1:0] QS = IN_W'(Q);
  localparam logic [OUT_W-1:0]       QL = OUT_W'(Q);

  logic [OUT_W-1:0] r_d;

  // result fits OUT_W bits, so add/subtract q modulo 2^OUT_W on the low slice
  always_comb begin
    if (x_in < 0) begin
      r_d = x_in[OUT_W-1:0] + QL;
    end else if (x_in >= QS) begin
      r_d = x_in[OUT_W-1:0] - QL;
    end else begin
      r_d = x_in[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      r_q     <= '0;
    end else begin
      valid_q <= en_in;
      if (en_in) begin
        r_q <= r_d;
      end
    end
  end

endmodule

// File: rtl/modfold_reduce.sv
module modfold_reduce
  import modfold_pkg::*;
#(
  parameter int unsigned PROD_W = 24,
  parameter int unsigned FOLD_K = 13,
  parameter int unsigned FOLD_S = 8,
  localparam int unsigned Q     = fold_modulus(FOLD_K, FOLD_S),
  localparam int unsigned RES_W = $clog2(Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PROD_W-1:0] in_prod,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_res
);

  localparam int unsigned KB = $clog2(FOLD_K + 1);
  localparam int unsigned W0 = PROD_W + 1;
  localparam int unsigned W1 = fold_width(PROD_W - FOLD_S, KB, FOLD_S);
  localparam int unsigned W2 = fold_width(W1 - FOLD_S, KB, FOLD_S);

  logic signed [W0-1:0] prod_s;
  logic                 v1;
  logic signed [W1-1:0] f1;
  logic                 v2;
  logic signed [W2-1:0] f2;

  assign prod_s = {1'b0, in_prod};

  modfold_pass #(.IN_W(W0), .OUT_W(W1), .K(FOLD_K), .S(FOLD_S)) u_pass1 (
    .clk(clk), .rst_n(rst_n), .en_in(in_valid), .x_in(prod_s),
    .valid_q(v1), .y_q(f1)
  );

  modfold_pass #(.IN_W(W1), .OUT_W(W2), .K(FOLD_K), .S(FOLD_S)) u_pass2 (
    .clk(clk), .rst_n(rst_n), .en_in(v1), .x_in(f1),
    .valid_q(v2), .y_q(f2)
  );

  modfold_canon #(.IN_W(W2), .Q(Q), .OUT_W(RES_W)) u_canon (
    .clk(clk), .rst_n(rst_n), .en_in(v2), .x_in(f2),
    .valid_q(out_valid), .r_q(out_res)
  );

endmodule

// File: rtl/modfold_reduce_chk.sv
module modfold_reduce_chk #(
  parameter int unsigned PROD_W = 24,
  parameter int unsigned FOLD_K = 13,
  parameter int unsigned FOLD_S = 8,
  parameter int unsigned Q      = 3329,
  parameter int unsigned RES_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PROD_W-1:0] in_prod,
  input logic              out_valid,
  input logic [RES_W-1:0]  out_res
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= 2'd0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (out_valid == 1'b0 && out_res == '0); // R6
    end
  end

  AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_res) < Q)); // R2

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R3

  AST_RES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid) |->
      (64'(out_res) == ((64'(FOLD_K * FOLD_K) * 64'($past(in_prod, 3))) % 64'(Q)))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !out_valid) |-> $stable(out_res)); // R5

endmodule

bind modfold_reduce modfold_reduce_chk #(
  .PROD_W(PROD_W), .FOLD_K(FOLD_K), .FOLD_S(FOLD_S), .Q(Q), .RES_W(RES_W)
) u_modfold_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prod(in_prod),
  .out_valid(out_valid), .out_res(out_res)
);

// File: tb/tb_modfold_reduce.sv
`timescale 1ns/1ps
module tb_modfold_reduce;

  localparam int unsigned QM = 3329;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_prod;
  logic        out_valid;
  logic [11:0] out_res;

  typedef struct {
    int unsigned exp;
    longint      issued;
    string       tag;
  } item_t;

  item_t       sb[$];
  item_t       mon_it;
  int          total;
  int          bad;
  longint      cyc;
  bit          started;
  bit          done;
  logic [11:0] last_res;

  modfold_reduce dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prod(in_prod),
    .out_valid(out_valid), .out_res(out_res)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  function automatic int unsigned ref_res(input logic [23:0] c);
    return int'((longint'(c) * 169) % longint'(QM));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [23:0] c, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_prod  = c;
    it.exp    = ref_res(c);
    it.issued = cyc;
    it.tag    = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_prod  = 24'($urandom);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R3 strobe without pending input", 1, 0);
        end else begin
          mon_it = sb.pop_front();
          chk(out_res == 12'(mon_it.exp), mon_it.tag, out_res, mon_it.exp);
          chk(32'(out_res) < QM, "R2 residue range", out_res, QM - 1);
          chk((cyc - mon_it.issued) == 3, "R3 latency", cyc - mon_it.issued, 3);
          last_res = out_res;
        end
      end else begin
        chk(out_res == last_res, "R5 residue hold while idle", out_res, last_res);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total    = 0;
    bad      = 0;
    started  = 1'b0;
    done     = 1'b0;
    last_res = '0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_prod  = 24'hABCDEF;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6 strobe in reset", out_valid, 0);
    chk(out_res == 12'd0, "R6 residue in reset", out_res, 0);
    rst_n   = 1'b1;
    started = 1'b1;

    // R7 corners
    drive(24'd0, "R7 zero");
    drive(24'hFFFFFF, "R7 all ones");
    chk(ref_res(24'hFFFFFF) == 87, "R7 model of all ones", ref_res(24'hFFFFFF), 87);
    drive(24'(QM), "R7 one q");
    drive(24'(5039 * QM), "R7 largest multiple of q");
    foreach (sb[i]) begin end
    for (int k = 2; k < 5039; k += 523) drive(24'(k * QM), "R7 multiple of q");
    drive(24'd1, "R1 one");
    drive(24'd255, "R1 byte max");
    drive(24'd256, "R8 first upper bit");
    drive(24'(QM - 1), "R1 q minus one");
    drive(24'h00FF00, "R8 negative fold");
    idle(5);

    // walking ones, gapped
    for (int b = 0; b < 24; b++) begin
      drive(24'(1) << b, "R8 walking bit");
      if (b % 3 == 0) idle(1);
    end
    idle(4);

    // back-to-back random stream
    for (int i = 0; i < 300; i++) drive(24'($urandom), "R4 back-to-back");
    idle(4);

    // random with irregular gaps
    for (int i = 0; i < 200; i++) begin
      drive(24'($urandom), "R1 random gapped");
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(6);

    chk(sb.size() == 0, "R4 all results delivered", sb.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule